// File: doc/BRIEF.md
# Feedback Switch Glitch Guard

This block sits in the control path of a delay-locked clock multiplier. It watches the enable that makes the fifth delay-line stage the feedback tap. When that enable changes, the loop can see a spurious phase step. The block answers each change with a correction request that tells the charge pump which way to move the control voltage.

When the tap moves away from stage 5, the enable falls. Every cell then has to get faster, so the block raises `set_upper_o`, which asks for a shorter delay. When the tap moves onto stage 5, the enable rises. Every cell then has to slow down, so the block raises `set_lower_o`, which asks for a longer delay.

A request stays high until the next rising edge of the reference clock. Both the enable and the reference clock come from other clock domains. The block therefore oversamples each of them with a fast system clock through a synchronizer chain. It finds edges by comparing each synchronized value with its value one cycle earlier.

Top module: `fsg_glitch_guard`

## Requirements
- R1: Each transition of the synchronized enable produces exactly one single-cycle edge pulse of the matching direction (a rise pulse or a fall pulse), and never both in the same cycle.
- R2: A falling edge of the enable drives `set_upper_o` high and `set_lower_o` low.
- R3: A rising edge of the enable drives `set_lower_o` high and `set_upper_o` low.
- R4: A rising edge of the reference clock drives both requests low. A falling edge of the reference clock has no effect on the outputs.
- R5: `set_upper_o` and `set_lower_o` are never high together. A new request of one polarity clears a pending request of the other polarity.
- R6: If an enable edge and a reference rising edge are detected in the same system cycle, the request that the enable edge calls for is asserted and held.
- R7: While `rst_n` is low at a rising `clk` edge, both requests are cleared, together with the synchronizer and edge history. If the enable is low when reset is released, no request follows.
- R8: With the default two-stage synchronizer, a change on the enable or on the reference clock that is applied between two `clk` rising edges reaches the outputs on the third `clk` rising edge after the change, and not earlier.
- R9: Once a request is raised, it stays unchanged until the next reference rising edge or the next enable edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that oversamples both watched signals |
| rst_n | input | 1 | Synchronous reset, active low |
| fb5_en_i | input | 1 | Enable that selects delay-line stage 5 as the feedback tap (asynchronous) |
| ref_clk_i | input | 1 | Reference clock, sampled as data (asynchronous) |
| set_upper_o | output | 1 | Request to shorten the delay (charge the loop filter) |
| set_lower_o | output | 1 | Request to lengthen the delay (discharge the loop filter) |

## Verification
The block holds three kinds of internal state: a stuck synchronizer flop, a lost edge-history value, and a holding register with the wrong priority. Each of these shows at the ports as a request that is missing, late, of the wrong polarity, or held past its reference edge. Because every path is only three registers deep, any such fault shows within four system cycles of the stimulus that exposes it. The bench therefore checks at a fixed sampling point after each stimulus. It also counts cycles exactly in the latency and short-pulse cases, so that a request arriving one cycle early or late is caught.

// File: rtl/fsg_pkg.sv
// Package: shared types for the feedback switch glitch guard.
// Assumes: nothing; it holds only type definitions.
package fsg_pkg;

    // Which transition an edge detector instance reports.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    // Held correction request; at most one field is high at a time.
    typedef struct packed {
        logic shorten;
        logic lengthen;
    } corr_req_t;

endpackage

// File: rtl/fsg_sync.sv
// Module: fsg_sync
// Carries an asynchronous level into the clk domain through a chain of
// STAGES flops. Assumes the source stays stable for longer than one clk
// period, so that each level is captured. The reset value is 0.
module fsg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // Purpose: capture the asynchronous input in the first flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_i;
    end

    // Purpose: shift the captured value through the remaining stages.
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/fsg_edge.sv
// Module: fsg_edge
// Emits a one-cycle pulse when a synchronized level changes in the
// direction that KIND selects. Assumes the input is already synchronous to
// clk. The history flop resets to 0.
module fsg_edge #(
    parameter fsg_pkg::edge_kind_e KIND = fsg_pkg::EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);
    logic prev_q;

    // Purpose: remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    // Purpose: compare the current level with the stored one for the selected direction.
    generate
        if (KIND == fsg_pkg::EDGE_RISE) begin : g_rise
            assign pulse_o = level_i & ~prev_q;
        end else begin : g_fall
            assign pulse_o = ~level_i & prev_q;
        end
    endgenerate

    // A level change makes a pulse for one cycle only (R1).
    assert_pulse_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/fsg_hold.sv
// Module: fsg_hold
// Holds the correction request. An enable fall sets the shorten request and
// an enable rise sets the lengthen request; each one clears the other. A
// reference rising edge clears both, unless an enable edge arrives in the
// same cycle. Assumes the shorten and lengthen pulses are never high together.
module fsg_hold (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shorten_i,
    input  logic                lengthen_i,
    input  logic                ref_rise_i,
    output fsg_pkg::corr_req_t  req_o
);
    fsg_pkg::corr_req_t req_q;

    // Purpose: set, swap or clear the held request, giving enable edges priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (shorten_i) begin
            req_q.shorten  <= 1'b1;
            req_q.lengthen <= 1'b0;
        end else if (lengthen_i) begin
            req_q.shorten  <= 1'b0;
            req_q.lengthen <= 1'b1;
        end else if (ref_rise_i) begin
            req_q <= '0;
        end
    end

    assign req_o = req_q;

    // The two enable edge pulses never coincide (R1).
    assert_edges_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(shorten_i && lengthen_i));
    // A fall edge leads to a shorten request (R2, R6).
    assert_fall_sets_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shorten_i |=> (req_o.shorten && !req_o.lengthen));
    // A rise edge leads to a lengthen request (R3, R6).
    assert_rise_sets_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lengthen_i |=> (req_o.lengthen && !req_o.shorten));
    // A reference edge with no enable edge clears both requests (R4).
    assert_ref_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise_i && !shorten_i && !lengthen_i) |=> (req_o == '0));
    // With no event, the request holds (R9).
    assert_request_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_rise_i && !shorten_i && !lengthen_i) |=> $stable(req_o));
endmodule

// File: rtl/fsg_glitch_guard.sv
// Module: fsg_glitch_guard (top)
// Turns changes of the stage-5 feedback enable into charge-pump correction
// requests, and holds each request until the next reference rising edge.
// Assumes clk is fast enough to see every level of both asynchronous inputs.
module fsg_glitch_guard #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb5_en_i,
    input  logic ref_clk_i,
    output logic set_upper_o,
    output logic set_lower_o
);
    logic en_s, ref_s;
    logic en_fall, en_rise, ref_rise;
    fsg_pkg::corr_req_t req;

    // Purpose: bring the enable into the clk domain.
    fsg_sync #(.STAGES(SYNC_STAGES)) u_sync_en (
        .clk(clk), .rst_n(rst_n), .async_i(fb5_en_i), .sync_o(en_s));

    // Purpose: bring the reference clock into the clk domain as data.
    fsg_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
        .clk(clk), .rst_n(rst_n), .async_i(ref_clk_i), .sync_o(ref_s));

    // Purpose: detect the enable leaving stage 5.
    fsg_edge #(.KIND(fsg_pkg::EDGE_FALL)) u_en_fall (
        .clk(clk), .rst_n(rst_n), .level_i(en_s), .pulse_o(en_fall));

    // Purpose: detect the enable selecting stage 5.
    fsg_edge #(.KIND(fsg_pkg::EDGE_RISE)) u_en_rise (
        .clk(clk), .rst_n(rst_n), .level_i(en_s), .pulse_o(en_rise));

    // Purpose: detect the reference rising edge that ends a request.
    fsg_edge #(.KIND(fsg_pkg::EDGE_RISE)) u_ref_rise (
        .clk(clk), .rst_n(rst_n), .level_i(ref_s), .pulse_o(ref_rise));

    // Purpose: hold the request until it is cleared.
    fsg_hold u_hold (
        .clk(clk), .rst_n(rst_n), .shorten_i(en_fall), .lengthen_i(en_rise),
        .ref_rise_i(ref_rise), .req_o(req));

    assign set_upper_o = req.shorten;
    assign set_lower_o = req.lengthen;

    // The two requests are never high together (R5).
    assert_requests_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_upper_o && set_lower_o));
    // Reset clears both requests (R7).
    assert_reset_clears_R7: assert property (@(posedge clk)
        !rst_n |=> (!set_upper_o && !set_lower_o));
endmodule

// File: tb/test_fsg_glitch_guard.sv
module test_fsg_glitch_guard;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb5_en_i = 1'b0;
    logic ref_clk_i = 1'b0;
    logic set_upper_o, set_lower_o;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fsg_glitch_guard i_fsg_glitch_guard (
        .clk(clk), .rst_n(rst_n), .fb5_en_i(fb5_en_i), .ref_clk_i(ref_clk_i),
        .set_upper_o(set_upper_o), .set_lower_o(set_lower_o));

    // Each entry is {enable, reference, expected upper, expected lower}.
    // The inputs are held for four cycles, and the outputs are read afterwards.
    localparam int NVEC = 16;
    localparam logic [3:0] VEC [NVEC] = '{
        4'b1001, // R3: enable rises, so lower
        4'b1100, // R4: reference rises, so clear
        4'b1000, // R4: reference falls, no effect
        4'b0010, // R2: enable falls, so upper
        4'b0010, // R9: hold
        4'b1001, // R5: lower replaces upper
        4'b0010, // R5: upper replaces lower
        4'b0100, // R4: clear
        4'b1001, // R4: reference falls while lower is held
        4'b0110, // R6: fall and reference rise together, upper wins
        4'b0010, // R9: reference falls, hold
        4'b0100, // R4: clear
        4'b1001, // R3
        4'b1100, // R4
        4'b0010, // R2
        4'b1101  // R6: rise and reference rise together, lower wins
    };

    task automatic check(input string req, input logic up_e, input logic lo_e);
        checks++;
        if (set_upper_o !== up_e || set_lower_o !== lo_e) begin
            fails++;
            $display("FAIL %s: got upper=%b lower=%b, expected upper=%b lower=%b",
                     req, set_upper_o, set_lower_o, up_e, lo_e);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Reset state (R7)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 reset state", 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R7 after release", 1'b0, 1'b0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            fb5_en_i = VEC[i][3];
            ref_clk_i = VEC[i][2];
            repeat (4) @(posedge clk);
            @(negedge clk);
            check($sformatf("R2/R3/R4/R5/R6/R9 vector %0d", i), VEC[i][1], VEC[i][0]);
        end

        // Return to a clean state: lower is pending, enable is high.
        ref_clk_i = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        ref_clk_i = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R4 clean state", 1'b0, 1'b0);

        // Latency: the enable falls, and the request appears on the third edge (R8).
        fb5_en_i = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8 edge 1", 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R8 edge 2", 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R8 edge 3", 1'b1, 1'b0);

        // Latency of the reference clear (R8).
        ref_clk_i = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        ref_clk_i = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R8 clear edge 2", 1'b1, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R8 clear edge 3", 1'b0, 1'b0);

        // A one-cycle enable pulse gives two edge pulses in turn (R1).
        fb5_en_i = 1'b1;
        @(negedge clk);
        fb5_en_i = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R1 pulse rise", 1'b0, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R1 pulse fall", 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 no further edge", 1'b1, 1'b0);

        // Reset while a request is pending (R7).
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7 reset clears pending", 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R7 no spurious request", 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule